// File: doc/BRIEF.md
# Serial Address Match Filter

This block sits behind a character decoder and decides, character by character, whether the received stream is meant for this node. An address command is an in-band marker (a special code with a fixed value), and the first ordinary data character after it is the address. That address is compared with a locally held address register. Two rules decide the outcome. In multicast mode the address matches when it shares at least one set bit with the local register. In unicast mode every compared bit must be equal. The pass or block decision then applies to every following character until the next marker.

The all-ones pattern has two meanings. Received as an address, it is a broadcast and matches in either mode. Held in the local register, it selects promiscuous mode, where every character passes and address commands have no effect. The register resets to all ones, so the block passes everything until software writes a real address. A run-time select chooses whether the full 10-bit width or only the low 8 bits take part in all of these comparisons.

Each input character produces one output beat one clock later. That beat carries a pass flag and an address flag, so downstream logic can drop the address character if it wishes.

Top module: `addr_match_filter`

## Requirements
- R1: A valid character with `in_special`=1 and `in_data` equal to parameter `MARKER` (default 10'h0F7) arms the block. The next valid character with `in_special`=0 is the address, and its output beat has `out_is_addr`=1. Special characters received while armed do not count as the address, and they do not disarm the block.
- R2: In multicast mode (`mode_unicast`=0) the address matches when (address AND local register), masked to the active width, is nonzero.
- R3: An address whose active bits are all ones matches in both modes.
- R4: When the active bits of the local register are all ones (promiscuous), every valid character passes. This includes markers and addresses that would otherwise fail.
- R5: Reset sets the local register to all ones, so characters pass after reset without any marker.
- R6: In unicast mode (`mode_unicast`=1) the address matches only when all active bits equal the local register.
- R7: With `addr_wide`=0 only bits 7:0 of the address and of the register are compared, for the match, the broadcast and the promiscuous tests. With `addr_wide`=1 all 10 bits are compared.
- R8: Outside promiscuous mode, the address character and all later data and special characters pass exactly when the last address matched. A marker, and the characters between a marker and its address, are blocked. Before the first address after reset, characters are blocked.
- R9: A write (`la_we`=1) takes effect from the next cycle. A character in the same cycle as the write is judged with the old register value.
- R10: Each output beat appears one clock after its input. `out_pass` and `out_is_addr` are 0 whenever `out_valid` is 0, and all outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded character is present |
| in_data | input | 10 | Decoded character value |
| in_special | input | 1 | Character is a special code |
| mode_unicast | input | 1 | 1 = exact match, 0 = shared-bit match |
| addr_wide | input | 1 | 1 = 10-bit compare, 0 = 8-bit compare |
| la_we | input | 1 | Write strobe for the local address |
| la_wdata | input | 10 | New local address value |
| out_valid | output | 1 | Output beat present |
| out_pass | output | 1 | Character is accepted |
| out_is_addr | output | 1 | Character was the address |

## Verification
Two functions can fall in the same cycle: a write to the local address, and the evaluation of a character that depends on that address. The worst case is an address character. The bench provokes this by writing a new register value in the same cycle as a data character and in the same cycle as an address character. Its reference model judges each of those characters against the value held before the write, and judges the next character against the new value. A second overlap is a marker arriving while the block is already armed. The model expects the block to stay armed and still block, and the bench checks this.

// File: rtl/addr_match_filter.sv
module addr_match_filter #(
  parameter int W = 10,
  parameter int NW = 8,
  parameter logic [W-1:0] MARKER = W'(10'h0F7)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_special,
  input  logic         mode_unicast,
  input  logic         addr_wide,
  input  logic         la_we,
  input  logic [W-1:0] la_wdata,
  output logic         out_valid,
  output logic         out_pass,
  output logic         out_is_addr
);
  localparam logic [W-1:0] NMASK = (W'(1) << NW) - W'(1);

  logic [W-1:0] la_q;
  logic         armed_q;
  logic         match_q;

  logic [W-1:0] mask;
  logic [W-1:0] addr_m;
  logic [W-1:0] la_m;
  logic         promisc;
  logic         bcast;
  logic         hit;
  logic         is_mark;
  logic         is_addr;
  logic         pass_now;

  assign mask    = addr_wide ? '1 : NMASK;
  assign addr_m  = in_data & mask;
  assign la_m    = la_q & mask;
  assign promisc = (la_m == mask);
  assign bcast   = (addr_m == mask);
  assign hit     = bcast | (mode_unicast ? (addr_m == la_m) : |(addr_m & la_m));
  assign is_mark = in_valid & in_special & (in_data == MARKER);
  assign is_addr = in_valid & armed_q & ~in_special;

  always_comb begin
    if (promisc)      pass_now = 1'b1;
    else if (is_addr) pass_now = hit;
    else if (is_mark) pass_now = 1'b0;
    else              pass_now = match_q & ~armed_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la_q        <= '1;
      armed_q     <= 1'b0;
      match_q     <= 1'b0;
      out_valid   <= 1'b0;
      out_pass    <= 1'b0;
      out_is_addr <= 1'b0;
    end else begin
      if (la_we) la_q <= la_wdata;
      if (is_mark) begin
        armed_q <= 1'b1;
        match_q <= 1'b0;
      end else if (is_addr) begin
        armed_q <= 1'b0;
        match_q <= hit;
      end
      out_valid   <= in_valid;
      out_pass    <= in_valid & pass_now;
      out_is_addr <= is_addr;
    end
  end
endmodule

module addr_match_filter_chk #(
  parameter int W = 10,
  parameter int NW = 8,
  parameter logic [W-1:0] MARKER = W'(10'h0F7)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         in_special,
  input logic         mode_unicast,
  input logic         addr_wide,
  input logic [W-1:0] la_q,
  input logic         armed_q,
  input logic         out_valid,
  input logic         out_pass,
  input logic         out_is_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_pass && !out_is_addr)); // R10

  AST_RESET_PROMISC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (la_q == '1)); // R5

  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_wide && la_q == '1) |=> out_pass); // R4

  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && armed_q && !in_special && addr_wide && in_data == '1) |=> (out_pass && out_is_addr)); // R3

  AST_MARK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_special && in_data == MARKER && addr_wide && la_q != '1) |=> !out_pass); // R8

  AST_UNI_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && armed_q && !in_special && addr_wide && mode_unicast &&
     in_data != la_q && in_data != '1 && la_q != '1) |=> (!out_pass && out_is_addr)); // R6
endmodule

bind addr_match_filter addr_match_filter_chk #(.W(W), .NW(NW), .MARKER(MARKER)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_special(in_special), .mode_unicast(mode_unicast), .addr_wide(addr_wide),
  .la_q(la_q), .armed_q(armed_q), .out_valid(out_valid), .out_pass(out_pass),
  .out_is_addr(out_is_addr)
);

// File: tb/tb_addr_match_filter.sv
module tb_addr_match_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] MK = 10'h0F7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_special = 1'b0, mode_unicast = 1'b0, addr_wide = 1'b1, la_we = 1'b0;
  logic [9:0] in_data = '0, la_wdata = '0;
  logic out_valid, out_pass, out_is_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int m_la = 'h3FF;
  bit m_armed = 0;
  bit m_match = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_match_filter #(.W(10), .NW(8), .MARKER(MK)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_special(in_special), .mode_unicast(mode_unicast), .addr_wide(addr_wide),
    .la_we(la_we), .la_wdata(la_wdata), .out_valid(out_valid),
    .out_pass(out_pass), .out_is_addr(out_is_addr)
  );

  task automatic check3(string tag, bit ev, bit ep, bit ea);
    checks++;
    if (out_valid !== ev || out_pass !== ep || out_is_addr !== ea) begin
      failures++;
      $display("FAIL %s: got v=%0b p=%0b a=%0b expected v=%0b p=%0b a=%0b",
               tag, out_valid, out_pass, out_is_addr, ev, ep, ea);
    end
  endtask

  task automatic step(string tag, bit v, bit sp, int d, bit we = 0, int wd = 0);
    int msk;
    int am;
    int lm;
    bit prom;
    bit ok;
    bit mark;
    bit adr;
    bit ep;
    in_valid = v; in_special = sp; in_data = d[9:0]; la_we = we; la_wdata = wd[9:0];
    msk = addr_wide ? 'h3FF : 'h0FF;
    am = d & msk;
    lm = m_la & msk;
    prom = (lm == msk);
    if (am == msk) ok = 1;
    else if (mode_unicast) ok = (am == lm);
    else ok = ((am & lm) != 0);
    mark = v && sp && (d == MK);
    adr = v && m_armed && !sp;
    if (!v) ep = 0;
    else if (prom) ep = 1;
    else if (adr) ep = ok;
    else if (mark || m_armed) ep = 0;
    else ep = m_match;
    if (mark) begin m_armed = 1; m_match = 0; end
    else if (adr) begin m_armed = 0; m_match = ok; end
    if (we) m_la = wd;
    @(posedge clk);
    @(negedge clk);
    check3(tag, v, ep, adr);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got running expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check3("R10 reset", 0, 0, 0);
    rst_n = 1'b1;
    step("R5 data after reset", 1, 0, 'h012);
    step("R5 special after reset", 1, 1, 'h1BC);
    step("R10 idle", 0, 0, 'h3FF);
    step("R4 marker promisc", 1, 1, MK);
    step("R4 address promisc", 1, 0, 'h000);
    step("R9 write with data", 1, 0, 'h055, 1, 'h005);
    step("R8 data blocked no match", 1, 0, 'h044);
    step("R1 marker", 1, 1, MK);
    step("R1 special while armed", 1, 1, 'h1BC);
    step("R1 marker while armed", 1, 1, MK);
    step("R2 address shares bit", 1, 0, 'h004);
    step("R8 data held pass", 1, 0, 'h123);
    step("R8 special held pass", 1, 1, 'h1BC);
    step("R10 idle gap", 0, 0, 'h000);
    step("R8 data still pass", 1, 0, 'h000);
    step("R1 marker", 1, 1, MK);
    step("R2 address no shared bit", 1, 0, 'h00A);
    step("R8 data held block", 1, 0, 'h001);
    step("R1 marker", 1, 1, MK);
    step("R3 broadcast", 1, 0, 'h3FF);
    step("R8 after broadcast", 1, 0, 'h010);
    mode_unicast = 1'b1;
    step("R1 marker", 1, 1, MK);
    step("R9 write with address", 1, 0, 'h155, 1, 'h154);
    step("R8 data after", 1, 0, 'h099);
    step("R1 marker", 1, 1, MK);
    step("R6 exact", 1, 0, 'h154);
    step("R1 marker", 1, 1, MK);
    step("R6 one bit off", 1, 0, 'h150);
    step("R8 data block", 1, 0, 'h154);
    step("R1 marker", 1, 1, MK);
    step("R3 broadcast unicast", 1, 0, 'h3FF);
    addr_wide = 1'b0;
    step("R1 marker", 1, 1, MK, 1, 'h233);
    step("R7 narrow unicast high bits ignored", 1, 0, 'h133);
    step("R1 marker", 1, 1, MK);
    step("R7 narrow broadcast", 1, 0, 'h0FF);
    mode_unicast = 1'b0;
    step("R1 marker", 1, 1, MK, 1, 'h201);
    step("R7 narrow multicast miss", 1, 0, 'h3FE);
    step("R7 write narrow promisc", 1, 0, 'h000, 1, 'h1FF);
    step("R7 narrow promisc pass", 1, 0, 'h000);
    step("R7 narrow promisc marker", 1, 1, MK);
    step("R7 narrow promisc address", 1, 0, 'h200);
    addr_wide = 1'b1;
    step("R7 wide same register not promisc", 1, 0, 'h000);
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (i % 50 == 0) begin
        mode_unicast = $urandom_range(0, 1);
        addr_wide = $urandom_range(0, 1);
      end
      if (r < 3) step("R8 random marker", 1, 1, MK);
      else if (r < 4) step("R9 random write", $urandom_range(0, 1), 0, $urandom_range(0, 1023),
                           1, ($urandom_range(0, 7) == 0) ? 'h3FF : $urandom_range(0, 1023));
      else if (r < 5) step("R10 random idle", 0, 0, $urandom_range(0, 1023));
      else if (r < 7) step("R1 random special", 1, 1, $urandom_range(0, 1023));
      else step("R2 random data", 1, 0, ($urandom_range(0, 9) == 0) ? 'h3FF : $urandom_range(0, 1023));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule